// File: doc/BRIEF.md
# Dual-Slope Measurement Sequencer

This block is the digital controller of a dual-slope integrating converter with a range of plus or minus 19999 counts. It runs the analog front end through three phases on a fixed clock budget, and each phase has its own switch enable. The first phase integrates the input signal for a fixed time. The second phase deintegrates against the reference until the comparator reports a zero crossing. The third phase is auto-zero, which takes up whatever time the deintegrate phase left unused. As a result, every measurement window is exactly 40002 clocks long, however large the input is.

The comparator output is the only analog observation. Its level at the end of integration gives the sign of the input. During deintegration, a change of that level away from the latched sign marks the zero crossing. The block latches the deintegrate count as the result. It raises an over-range flag when the count reaches the limit and an under-range flag for small results. It tells a display scanner when each window ends and when the first digit strobe is due. A run/hold level selects between free-running conversions and single conversions started by a pulse.

Top module: `dual_slope_ctrl`

## Requirements
- R1: While reset is low and afterwards, as long as run/hold stays low, `busy`, `over_range`, `under_range`, `eoc` and `first_strobe` are 0 and `result` is 0. `az_en` is 1 and `int_en` and `deint_en` are 0. At most one of the three phase enables is ever high.
- R2: With run/hold held high, consecutive rising edges of `busy` are exactly `INT_CLKS + OVR_CNT + 1 + AZ_MIN` clocks apart (40002 by default). `eoc` is high for one clock, the same clock in which `busy` rises for the next window.
- R3: After `busy` rises, `int_en` is high for exactly `INT_CLKS` clocks (10001). Then `deint_en` turns on.
- R4: `cmp_out` high means a positive input. A zero crossing is `cmp_out` differing from `polarity` during deintegrate. `busy` falls on the first clock after the crossing is sampled, and `az_en` turns on in that clock. `result` equals the number of deintegrate clocks before the sampled crossing. `busy` was high for `INT_CLKS + result + 1` clocks.
- R5: If the deintegrate count reaches `OVR_CNT` (20000), `busy` falls after `OVR_CNT + 1` deintegrate clocks whether or not a crossing occurred. In that case `result` saturates at `OVR_CNT` and `over_range` rises in the same clock as the fall of `busy`.
- R6: `over_range` stays high through the signal-integrate phase of the next window. It clears in the first deintegrate clock of that window.
- R7: `under_range` rises with the fall of `busy` when the result is not over-range and is `UR_LIMIT` (1800) or less. It clears in the clock in which `busy` next rises. It is never high together with `over_range`.
- R8: `polarity` takes the level of `cmp_out` sampled at the end of integration. It changes only at the start of deintegrate, and it is held for zero and for over-range results.
- R9: When run/hold is low at the end of a window, no new window starts. `eoc` still pulses, `busy` stays low, `az_en` stays high, and `result`, `over_range` and `under_range` keep their values.
- R10: While holding, run/hold is passed through a two-flop synchroniser. `busy` rises three clocks after run/hold is driven high. A pulse on run/hold that rises and falls before the current window ends starts nothing.
- R11: `first_strobe` is high for exactly one clock, `STROBE_DLY` clocks (101) after the clock in which `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_hold | input | 1 | High: free-running conversions. Low: hold after the current window. A pulse restarts conversion while holding. |
| cmp_out | input | 1 | Comparator level; high means a positive integrator state |
| busy | output | 1 | High from the start of integrate to the end of deintegrate |
| polarity | output | 1 | Sign of the last conversion, 1 for positive |
| over_range | output | 1 | Last conversion reached the count limit |
| under_range | output | 1 | Last conversion was at or below the low threshold |
| result | output | RES_W (15) | Latched deintegrate count |
| az_en | output | 1 | Auto-zero switch enable, also on while holding |
| int_en | output | 1 | Signal-integrate switch enable |
| deint_en | output | 1 | Reference deintegrate switch enable |
| eoc | output | 1 | One-clock pulse at the end of each window |
| first_strobe | output | 1 | One-clock marker for the first digit strobe |

## Verification
The comparator is modelled so that it flips after a chosen number of deintegrate clocks, with either input sign, and each window is timed by counting clocks. The crossing counts are chosen around the thresholds. A count of 0 checks the sign flags for a zero result. Counts just at and above the under-range limit tell the inclusive comparison from the exclusive one. A count one below the over-range limit and a count at it separate a saturated result from a real crossing, and a run with no crossing checks the saturation path. The restart is tried with a pulse that arrives after the window ends, which must start a conversion, and with one that arrives before, which must start nothing. This separates "restart only after completion" from a plain level or edge trigger.

// File: rtl/dsc_pkg.sv
// Shared types for the dual-slope sequencer.
// Assumes nothing beyond the 2-bit phase encoding below.
package dsc_pkg;

    // Measurement phases; HOLD keeps the auto-zero switch closed while idle.
    typedef enum logic [1:0] {
        PH_HOLD  = 2'd0,
        PH_INT   = 2'd1,
        PH_DEINT = 2'd2,
        PH_AZ    = 2'd3
    } phase_t;

endpackage

// File: rtl/dsc_sync.sv
// Multi-flop synchroniser for the asynchronous run/hold level.
// Assumes the input is a level or a pulse that lasts at least a few clocks.
module dsc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Capture the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // Pass the value one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/dsc_timer.sv
// Phase sequencer and window timer.
// Runs integrate, deintegrate and auto-zero. The fixed window keeps the
// total at CYCLE clocks, because auto-zero ends on the window counter
// rather than on its own length. Assumes zc is synchronous to clk and
// 1 <= STROBE_DLY < AZ_MIN.
module dsc_timer import dsc_pkg::*; #(
    parameter int INT_CLKS   = 10001,
    parameter int OVR_CNT    = 20000,
    parameter int AZ_MIN     = 10000,
    parameter int STROBE_DLY = 101,
    parameter int CNT_W      = 16,
    parameter int RES_W      = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_s,
    input  logic             zc,
    output phase_t           phase,
    output logic [RES_W-1:0] done_cnt,
    output logic             ev_start,
    output logic             ev_deint,
    output logic             ev_done,
    output logic             eoc,
    output logic             first_strobe
);

    localparam int CYCLE = INT_CLKS + OVR_CNT + 1 + AZ_MIN;

    phase_t           ph_nxt;
    logic [CNT_W-1:0] ph_cnt;
    logic [CNT_W-1:0] cyc_cnt;
    logic             win_last;
    logic             ev_win_end;
    logic             ev_strobe;

    // Next phase and one-clock events.
    always_comb begin
        ph_nxt     = phase;
        ev_start   = 1'b0;
        ev_deint   = 1'b0;
        ev_done    = 1'b0;
        ev_win_end = 1'b0;
        ev_strobe  = 1'b0;
        win_last   = (cyc_cnt == CNT_W'(CYCLE - 1));
        case (phase)
            PH_HOLD: begin
                if (run_s) begin
                    ph_nxt   = PH_INT;
                    ev_start = 1'b1;
                end
            end
            PH_INT: begin
                if (ph_cnt == CNT_W'(INT_CLKS - 1)) begin
                    ph_nxt   = PH_DEINT;
                    ev_deint = 1'b1;
                end
            end
            PH_DEINT: begin
                if (zc || (ph_cnt == CNT_W'(OVR_CNT))) begin
                    ph_nxt  = PH_AZ;
                    ev_done = 1'b1;
                end
            end
            PH_AZ: begin
                if (ph_cnt == CNT_W'(STROBE_DLY - 1)) ev_strobe = 1'b1;
                if (win_last) begin
                    ev_win_end = 1'b1;
                    if (run_s) begin
                        ph_nxt   = PH_INT;
                        ev_start = 1'b1;
                    end else begin
                        ph_nxt = PH_HOLD;
                    end
                end
            end
            default: ph_nxt = PH_HOLD;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_HOLD;
        else        phase <= ph_nxt;
    end

    // Per-phase counter: restarts on every phase change, idles in hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   ph_cnt <= '0;
        else if (ph_nxt != phase || phase == PH_HOLD) ph_cnt <= '0;
        else                                          ph_cnt <= ph_cnt + 1'b1;
    end

    // Window counter: 0 in the first integrate clock, wraps at window end.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cyc_cnt <= '0;
        else if (ev_start || ev_win_end) cyc_cnt <= '0;
        else if (phase != PH_HOLD)       cyc_cnt <= cyc_cnt + 1'b1;
    end

    // Registered markers for the display scanner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc          <= 1'b0;
            first_strobe <= 1'b0;
        end else begin
            eoc          <= ev_win_end;
            first_strobe <= ev_strobe;
        end
    end

    assign done_cnt = ph_cnt[RES_W-1:0];

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_cnt < CNT_W'(CYCLE)); // R2
    AST_INT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INT) |-> (ph_cnt < CNT_W'(INT_CLKS))); // R3
    AST_DEINT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DEINT) |-> (ph_cnt <= CNT_W'(OVR_CNT))); // R5
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD && $past(phase) == PH_HOLD) |-> $stable(cyc_cnt)); // R9

endmodule

// File: rtl/dsc_result.sv
// Result latch and status flags.
// Captures the sign at the start of deintegrate and the count at its end,
// and sets or clears BUSY and the range flags at the phase boundaries.
// Assumes UR_LIMIT < OVR_CNT and that done_cnt <= OVR_CNT.
module dsc_result #(
    parameter int OVR_CNT  = 20000,
    parameter int UR_LIMIT = 1800,
    parameter int RES_W    = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_out,
    input  logic             ev_start,
    input  logic             ev_deint,
    input  logic             ev_done,
    input  logic [RES_W-1:0] done_cnt,
    output logic             busy,
    output logic             polarity,
    output logic             over_range,
    output logic             under_range,
    output logic [RES_W-1:0] result
);

    logic ovr_now;
    logic ur_now;

    // Classify the finishing count.
    always_comb begin
        ovr_now = (done_cnt == RES_W'(OVR_CNT));
        ur_now  = !ovr_now && (done_cnt <= RES_W'(UR_LIMIT));
    end

    // BUSY spans integrate and deintegrate.
    always_ff @(posedge clk) begin
        if (!rst_n)        busy <= 1'b0;
        else if (ev_start) busy <= 1'b1;
        else if (ev_done)  busy <= 1'b0;
    end

    // Sign is taken from the comparator as deintegrate begins.
    always_ff @(posedge clk) begin
        if (!rst_n)        polarity <= 1'b0;
        else if (ev_deint) polarity <= cmp_out;
    end

    // Over-range: set at end of deintegrate, cleared at next deintegrate start.
    always_ff @(posedge clk) begin
        if (!rst_n)        over_range <= 1'b0;
        else if (ev_done)  over_range <= ovr_now;
        else if (ev_deint) over_range <= 1'b0;
    end

    // Under-range: set at end of deintegrate, cleared at next integrate start.
    always_ff @(posedge clk) begin
        if (!rst_n)        under_range <= 1'b0;
        else if (ev_done)  under_range <= ur_now;
        else if (ev_start) under_range <= 1'b0;
    end

    // Result count latch.
    always_ff @(posedge clk) begin
        if (!rst_n)       result <= '0;
        else if (ev_done) result <= done_cnt;
    end

    AST_OVR_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
        over_range |-> (result == RES_W'(OVR_CNT))); // R5
    AST_UR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        under_range |-> (result <= RES_W'(UR_LIMIT))); // R7
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(over_range && under_range)); // R7

endmodule

// File: rtl/dual_slope_ctrl.sv
// Top of the dual-slope converter sequencer.
// Joins the run/hold synchroniser, the phase timer and the result block,
// and decodes the analog switch enables from the phase. Assumes cmp_out
// is already synchronous to clk.
module dual_slope_ctrl import dsc_pkg::*; #(
    parameter int INT_CLKS    = 10001,
    parameter int OVR_CNT     = 20000,
    parameter int AZ_MIN      = 10000,
    parameter int UR_LIMIT    = 1800,
    parameter int STROBE_DLY  = 101,
    parameter int SYNC_STAGES = 2,
    localparam int CYCLE_CLKS = INT_CLKS + OVR_CNT + 1 + AZ_MIN,
    localparam int CNT_W      = $clog2(CYCLE_CLKS),
    localparam int RES_W      = $clog2(OVR_CNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_hold,
    input  logic             cmp_out,
    output logic             busy,
    output logic             polarity,
    output logic             over_range,
    output logic             under_range,
    output logic [RES_W-1:0] result,
    output logic             az_en,
    output logic             int_en,
    output logic             deint_en,
    output logic             eoc,
    output logic             first_strobe
);

    phase_t           phase;
    logic             run_s;
    logic             zc;
    logic [RES_W-1:0] done_cnt;
    logic             ev_start;
    logic             ev_deint;
    logic             ev_done;

    dsc_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (run_hold),
        .sync_out (run_s)
    );

    // Zero crossing: comparator has left the sign latched for this window.
    assign zc = cmp_out ^ polarity;

    dsc_timer #(
        .INT_CLKS   (INT_CLKS),
        .OVR_CNT    (OVR_CNT),
        .AZ_MIN     (AZ_MIN),
        .STROBE_DLY (STROBE_DLY),
        .CNT_W      (CNT_W),
        .RES_W      (RES_W)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_s        (run_s),
        .zc           (zc),
        .phase        (phase),
        .done_cnt     (done_cnt),
        .ev_start     (ev_start),
        .ev_deint     (ev_deint),
        .ev_done      (ev_done),
        .eoc          (eoc),
        .first_strobe (first_strobe)
    );

    dsc_result #(
        .OVR_CNT  (OVR_CNT),
        .UR_LIMIT (UR_LIMIT),
        .RES_W    (RES_W)
    ) u_result (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_out     (cmp_out),
        .ev_start    (ev_start),
        .ev_deint    (ev_deint),
        .ev_done     (ev_done),
        .done_cnt    (done_cnt),
        .busy        (busy),
        .polarity    (polarity),
        .over_range  (over_range),
        .under_range (under_range),
        .result      (result)
    );

    // Switch enables decoded from the phase register.
    always_comb begin
        az_en    = (phase == PH_AZ) || (phase == PH_HOLD);
        int_en   = (phase == PH_INT);
        deint_en = (phase == PH_DEINT);
    end

    AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({az_en, int_en, deint_en})); // R1
    AST_BUSY_TO_AZ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> az_en); // R4
    AST_POL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (deint_en && $past(deint_en)) |-> $stable(polarity)); // R8

endmodule

// File: tb/dual_slope_ctrl_bench.sv
// Directed bench: each task drives one scenario and checks its own results.
// Short phase lengths keep each window at 42 clocks.
module dual_slope_ctrl_bench;

    localparam int P_INT = 11;
    localparam int P_OVR = 20;
    localparam int P_AZ  = 10;
    localparam int P_UR  = 4;
    localparam int P_STB = 3;
    localparam int P_WIN = P_INT + P_OVR + 1 + P_AZ;
    localparam int RW    = $clog2(P_OVR + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_hold = 1'b0;
    logic          cmp_out = 1'b0;
    logic          busy, polarity, over_range, under_range;
    logic [RW-1:0] result;
    logic          az_en, int_en, deint_en, eoc, first_strobe;

    int checks = 0;
    int errors = 0;
    int ticks  = 0;
    int t_prev = 0;

    dual_slope_ctrl #(
        .INT_CLKS   (P_INT),
        .OVR_CNT    (P_OVR),
        .AZ_MIN     (P_AZ),
        .UR_LIMIT   (P_UR),
        .STROBE_DLY (P_STB)
    ) u_dual_slope_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_hold     (run_hold),
        .cmp_out      (cmp_out),
        .busy         (busy),
        .polarity     (polarity),
        .over_range   (over_range),
        .under_range  (under_range),
        .result       (result),
        .az_en        (az_en),
        .int_en       (int_en),
        .deint_en     (deint_en),
        .eoc          (eoc),
        .first_strobe (first_strobe)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Tick counter on the active edge and the watchdog.
    always @(posedge clk) begin
        ticks <= ticks + 1;
        if (ticks > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: ticks %0d expected below %0d", ticks, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One window: comparator flips after n deintegrate clocks (n < 0: never).
    task automatic measure_cycle(input logic sgn, input int n, input bit prev_ovr,
                                 output int rise_t, output bit eoc_rise);
        int  idx, hi, j, exp_res;
        bit  exp_ovr, exp_ur;
        cmp_out = sgn;
        j = 0;
        while (!busy && j < 200) begin
            @(negedge clk);
            j++;
        end
        rise_t   = ticks;
        eoc_rise = eoc;
        check_eq("R7", "under_range cleared at busy rise", int'(under_range), 0);
        check_eq("R3", "int_en at busy rise", int'(int_en), 1);
        check_eq("R6", "over_range held in integrate", int'(over_range), int'(prev_ovr));
        idx = 0;
        hi  = 0;
        while (busy && idx < 200) begin
            hi++;
            if (idx == P_INT) begin
                check_eq("R8", "polarity at deintegrate start", int'(polarity), int'(sgn));
                check_eq("R6", "over_range cleared at deintegrate", int'(over_range), 0);
                check_eq("R3", "deint_en after integrate", int'(deint_en), 1);
            end
            if (n >= 0 && idx == P_INT + n) cmp_out = ~sgn;
            idx++;
            @(negedge clk);
        end
        exp_ovr = (n < 0) || (n >= P_OVR);
        exp_res = exp_ovr ? P_OVR : n;
        exp_ur  = !exp_ovr && (n <= P_UR);
        check_eq(exp_ovr ? "R5" : "R4", "busy high clocks", hi, P_INT + exp_res + 1);
        check_eq(exp_ovr ? "R5" : "R4", "result", int'(result), exp_res);
        check_eq("R5", "over_range at busy fall", int'(over_range), int'(exp_ovr));
        check_eq("R7", "under_range at busy fall", int'(under_range), int'(exp_ur));
        check_eq("R8", "polarity held after deintegrate", int'(polarity), int'(sgn));
        check_eq("R4", "az_en at busy fall", int'(az_en), 1);
        j = 0;
        while (!first_strobe && j < 50) begin
            @(negedge clk);
            j++;
        end
        check_eq("R11", "first_strobe delay", j, P_STB);
        @(negedge clk);
        check_eq("R11", "first_strobe width", int'(first_strobe), 0);
    endtask

    // Free-running window: also checks period and end-of-cycle pulse.
    task automatic run_window(input logic sgn, input int n, input bit prev_ovr);
        int t;
        bit e;
        measure_cycle(sgn, n, prev_ovr, t, e);
        check_eq("R2", "window period", t - t_prev, P_WIN);
        check_eq("R2", "eoc with busy rise", int'(e), 1);
        t_prev = t;
    endtask

    task automatic test_reset();
        rst_n    = 1'b0;
        run_hold = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check_eq("R1", "busy idle", int'(busy), 0);
        check_eq("R1", "over_range idle", int'(over_range), 0);
        check_eq("R1", "under_range idle", int'(under_range), 0);
        check_eq("R1", "eoc idle", int'(eoc), 0);
        check_eq("R1", "first_strobe idle", int'(first_strobe), 0);
        check_eq("R1", "result idle", int'(result), 0);
        check_eq("R1", "az_en idle", int'(az_en), 1);
        check_eq("R1", "int_en idle", int'(int_en), 0);
        check_eq("R1", "deint_en idle", int'(deint_en), 0);
    endtask

    task automatic test_run_mode();
        int t;
        bit e;
        run_hold = 1'b1;
        measure_cycle(1'b1, 7, 1'b0, t, e);
        t_prev = t;
        run_window(1'b0, 3, 1'b0);
        run_window(1'b1, P_UR, 1'b0);
        run_window(1'b1, P_UR + 1, 1'b0);
        run_window(1'b0, -1, 1'b0);
        run_window(1'b1, 0, 1'b1);
        run_window(1'b1, P_OVR - 1, 1'b0);
        run_window(1'b1, P_OVR, 1'b0);
    endtask

    task automatic test_hold();
        int j;
        bit ok;
        run_hold = 1'b0;
        j = 0;
        while (!eoc && j < 100) begin
            @(negedge clk);
            j++;
        end
        check_eq("R9", "eoc at held window end", int'(eoc), 1);
        ok = 1'b1;
        repeat (60) begin
            @(negedge clk);
            if (busy || !az_en) ok = 1'b0;
        end
        check_eq("R9", "idle while held", int'(ok), 1);
        check_eq("R9", "result kept while held", int'(result), P_OVR);
        check_eq("R9", "over_range kept while held", int'(over_range), 1);
    endtask

    task automatic test_restart();
        int  t, j;
        bit  e, ok;
        run_hold = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_eq("R10", "busy before sync delay", int'(busy), 0);
        @(negedge clk);
        check_eq("R10", "busy after restart pulse", int'(busy), 1);
        run_hold = 1'b0;
        measure_cycle(1'b0, 2, 1'b1, t, e);
        // Pulse inside the window, before it ends: must be ignored.
        run_hold = 1'b1;
        repeat (3) @(negedge clk);
        run_hold = 1'b0;
        j = 0;
        while (!eoc && j < 100) begin
            @(negedge clk);
            j++;
        end
        check_eq("R9", "eoc after single window", int'(eoc), 1);
        ok = 1'b1;
        repeat (60) begin
            @(negedge clk);
            if (busy) ok = 1'b0;
        end
        check_eq("R10", "early pulse ignored", int'(ok), 1);
    endtask

    initial begin
        test_reset();
        test_run_mode();
        test_hold();
        test_restart();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule